// File: doc/BRIEF.md
# Per-Slot Scratchpad Bank Index Mapper

This block turns a scratchpad word address into a bank index and a row inside that bank. It does this combinationally. Each resident thread block occupies a slot, and each slot has its own mapping configuration, because every thread block addresses a scratchpad space of its own. There are three mappings. The first takes the low address bits directly. The second folds the upper index-width field onto the lower one with XOR, and it is the mapping every slot starts with. The third is a programmable pair hash, where each index bit is the XOR of two address bits chosen per slot.

The configuration is loaded through a simple write port into a pending copy per slot. Nothing about the mapping in use changes at that point. When a new thread block is launched on a slot, the pending copy becomes the active copy at that clock edge. That new block therefore runs under one fixed mapping for its whole life, and the new mapping costs one cycle to apply. Deciding which configuration is good belongs to logic outside this block.

Top module: `xbm_top`

## Requirements
- R1: After reset, every slot maps with the fold hash: bank = addr[4:0] XOR addr[9:5].
- R2: Mode code 0 (basic) gives bank = addr[4:0].
- R3: Mode code 2 (pair) gives bank bit i = addr[A_i] XOR addr[B_i]. A_i is cfg_sel_a[4i+3:4i] and B_i is cfg_sel_b[4i+3:4i].
- R4: In pair mode, when A_i equals B_i, bank bit i equals addr[A_i].
- R5: In pair mode, a selector value of 10 or more contributes a constant 0.
- R6: The row output is always addr[9:5], in every mode.
- R7: A configuration write only changes the pending copy of its slot. The mapping seen at the outputs stays the same until a launch on that slot.
- R8: A launch on a slot copies that slot's pending configuration into its active one at the launching clock edge. The new mapping shows from the cycle after that edge. A write to the same slot in the launch cycle goes only into the pending copy.
- R9: A write or a launch on one slot leaves the mapping of every other slot unchanged.
- R10: Mode code 1 (fold) and mode code 3 (reserved) both map with the fold hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write the pending configuration of cfg_slot |
| cfg_slot | input | 2 | Slot whose pending configuration is written |
| cfg_mode | input | 2 | Mode code: 0 basic, 1 fold, 2 pair, 3 fold |
| cfg_sel_a | input | 20 | First bit selector per index bit, 4 bits each |
| cfg_sel_b | input | 20 | Second bit selector per index bit, 4 bits each |
| launch_valid | input | 1 | A thread block is launched on launch_slot |
| launch_slot | input | 2 | Slot being launched |
| req_slot | input | 2 | Slot of the current access |
| req_addr | input | 10 | Scratchpad word address of the access |
| bank_idx | output | 5 | Bank index |
| row | output | 5 | Row within the bank |

## Verification
A corrupted active configuration shows up on bank_idx in the same cycle that any address is presented for that slot. The bench therefore probes every slot with several addresses after each write and each launch. A pending copy that is wrong cannot be seen until the next launch on that slot. For that reason each write is followed by a launch and a probe, and probes just before and just after the launching edge pin down the one-cycle apply latency. Probes of the slots not being touched catch any write or launch that reaches the wrong slot.

// File: rtl/xbm_pkg.sv
// Shared definitions for the bank index mapper.
// Assumes a 2-bit mode code carried on the configuration port.
package xbm_pkg;
    typedef enum logic [1:0] {
        MAP_BASIC = 2'd0,
        MAP_FOLD  = 2'd1,
        MAP_PAIR  = 2'd2,
        MAP_RSVD  = 2'd3
    } map_mode_e;
endpackage

// File: rtl/xbm_cfg_store.sv
// Pending and active mapping configuration, one pair per thread-block slot.
// A write lands in the pending copy. A launch copies pending into active.
// Assumes the slot numbers on the inputs are below SLOTS.
module xbm_cfg_store
    import xbm_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 5,
    parameter int SEL_W  = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CFG_W  = IDX_W * SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [1:0]                  wr_mode,
    input  logic [CFG_W-1:0]            wr_sel_a,
    input  logic [CFG_W-1:0]            wr_sel_b,
    input  logic                        launch_en,
    input  logic [SLOT_W-1:0]           launch_slot,
    output logic [SLOTS-1:0][1:0]       pend_mode,
    output logic [SLOTS-1:0][CFG_W-1:0] pend_sel_a,
    output logic [SLOTS-1:0][CFG_W-1:0] pend_sel_b,
    output logic [SLOTS-1:0][1:0]       act_mode,
    output logic [SLOTS-1:0][CFG_W-1:0] act_sel_a,
    output logic [SLOTS-1:0][CFG_W-1:0] act_sel_b
);

    // Reset selector set: A_i = i, B_i = i + IDX_W (the fold pairs).
    function automatic logic [CFG_W-1:0] reset_sel(input bit upper);
        logic [CFG_W-1:0] v;
        v = '0;
        for (int i = 0; i < IDX_W; i++) begin
            if (upper && (i + IDX_W < ADDR_W))
                v[i*SEL_W +: SEL_W] = SEL_W'(i + IDX_W);
            else
                v[i*SEL_W +: SEL_W] = SEL_W'(i);
        end
        return v;
    endfunction

    localparam logic [CFG_W-1:0] RST_SEL_A = reset_sel(1'b0);
    localparam logic [CFG_W-1:0] RST_SEL_B = reset_sel(1'b1);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic             hit_wr;
        logic             hit_launch;
        logic [1:0]       p_mode;
        logic [CFG_W-1:0] p_sel_a;
        logic [CFG_W-1:0] p_sel_b;
        logic [1:0]       a_mode;
        logic [CFG_W-1:0] a_sel_a;
        logic [CFG_W-1:0] a_sel_b;

        assign hit_wr     = wr_en     && (wr_slot     == SLOT_W'(s));
        assign hit_launch = launch_en && (launch_slot == SLOT_W'(s));

        // Pending copy: accepts configuration writes for this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                p_mode  <= MAP_FOLD;
                p_sel_a <= RST_SEL_A;
                p_sel_b <= RST_SEL_B;
            end else if (hit_wr) begin
                p_mode  <= wr_mode;
                p_sel_a <= wr_sel_a;
                p_sel_b <= wr_sel_b;
            end
        end

        // Active copy: takes the pre-edge pending value on a launch of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_mode  <= MAP_FOLD;
                a_sel_a <= RST_SEL_A;
                a_sel_b <= RST_SEL_B;
            end else if (hit_launch) begin
                a_mode  <= p_mode;
                a_sel_a <= p_sel_a;
                a_sel_b <= p_sel_b;
            end
        end

        assign pend_mode[s]  = p_mode;
        assign pend_sel_a[s] = p_sel_a;
        assign pend_sel_b[s] = p_sel_b;
        assign act_mode[s]   = a_mode;
        assign act_sel_a[s]  = a_sel_a;
        assign act_sel_b[s]  = a_sel_b;
    end

endmodule

// File: rtl/xbm_index.sv
// Combinational bank index and row computation for one configuration.
// Assumes ADDR_W > IDX_W. A selector value of ADDR_W or more reads as 0.
module xbm_index
    import xbm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 5,
    parameter int SEL_W  = 4,
    localparam int CFG_W = IDX_W * SEL_W,
    localparam int ROW_W = ADDR_W - IDX_W
) (
    input  logic [1:0]        mode,
    input  logic [CFG_W-1:0]  sel_a,
    input  logic [CFG_W-1:0]  sel_b,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  bank,
    output logic [ROW_W-1:0]  row
);

    // The row is the field above the low index bits, in every mode.
    assign row = addr[ADDR_W-1:IDX_W];

    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        logic [SEL_W-1:0] sa;
        logic [SEL_W-1:0] sb;
        logic             pa;
        logic             pb;
        logic             hi;
        logic             pair;
        logic             b;

        assign sa = sel_a[i*SEL_W +: SEL_W];
        assign sb = sel_b[i*SEL_W +: SEL_W];

        // Pick the address bit named by each selector; out of range gives 0.
        always_comb begin
            pa = 1'b0;
            pb = 1'b0;
            for (int k = 0; k < ADDR_W; k++) begin
                if (sa == SEL_W'(k)) pa = addr[k];
                if (sb == SEL_W'(k)) pb = addr[k];
            end
        end

        // A repeated selector uses a single address bit instead of cancelling.
        assign pair = (sa == sb) ? pa : (pa ^ pb);

        // Fold partner bit exists only when the address is wide enough.
        if (i + IDX_W < ADDR_W) begin : g_hi
            assign hi = addr[i + IDX_W];
        end else begin : g_nohi
            assign hi = 1'b0;
        end

        // Mode select for this index bit.
        always_comb begin
            case (map_mode_e'(mode))
                MAP_BASIC: b = addr[i];
                MAP_PAIR:  b = pair;
                default:   b = addr[i] ^ hi;
            endcase
        end

        assign bank[i] = b;
    end

endmodule

// File: rtl/xbm_top.sv
// Per-slot bank index mapper: holds configurations per thread-block slot
// and maps each access using the active configuration of its slot.
// Assumes the slot inputs stay below SLOTS and SLOTS is a power of two.
module xbm_top
    import xbm_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 5,
    parameter int SEL_W  = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CFG_W  = IDX_W * SEL_W,
    localparam int ROW_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [1:0]        cfg_mode,
    input  logic [CFG_W-1:0]  cfg_sel_a,
    input  logic [CFG_W-1:0]  cfg_sel_b,
    input  logic              launch_valid,
    input  logic [SLOT_W-1:0] launch_slot,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  bank_idx,
    output logic [ROW_W-1:0]  row
);

    logic [SLOTS-1:0][1:0]       pend_mode;
    logic [SLOTS-1:0][CFG_W-1:0] pend_sel_a;
    logic [SLOTS-1:0][CFG_W-1:0] pend_sel_b;
    logic [SLOTS-1:0][1:0]       act_mode;
    logic [SLOTS-1:0][CFG_W-1:0] act_sel_a;
    logic [SLOTS-1:0][CFG_W-1:0] act_sel_b;
    logic [1:0]                  cur_mode;
    logic [CFG_W-1:0]            cur_sel_a;
    logic [CFG_W-1:0]            cur_sel_b;

    xbm_cfg_store #(
        .SLOTS(SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_slot(cfg_slot), .wr_mode(cfg_mode),
        .wr_sel_a(cfg_sel_a), .wr_sel_b(cfg_sel_b),
        .launch_en(launch_valid), .launch_slot(launch_slot),
        .pend_mode(pend_mode), .pend_sel_a(pend_sel_a), .pend_sel_b(pend_sel_b),
        .act_mode(act_mode), .act_sel_a(act_sel_a), .act_sel_b(act_sel_b)
    );

    // Pick the active configuration of the requesting slot.
    always_comb begin
        cur_mode  = act_mode[req_slot];
        cur_sel_a = act_sel_a[req_slot];
        cur_sel_b = act_sel_b[req_slot];
    end

    xbm_index #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_index (
        .mode(cur_mode), .sel_a(cur_sel_a), .sel_b(cur_sel_b),
        .addr(req_addr), .bank(bank_idx), .row(row)
    );

endmodule

// File: rtl/xbm_checker.sv
// Temporal checks on the mapper, bound to xbm_top.
// Assumes ADDR_W >= 2*IDX_W for the fold check.
module xbm_checker #(
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 5,
    parameter int SEL_W  = 4,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CFG_W  = IDX_W * SEL_W,
    localparam int ROW_W  = ADDR_W - IDX_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_we,
    input logic [SLOT_W-1:0]           cfg_slot,
    input logic [1:0]                  cfg_mode,
    input logic                        launch_valid,
    input logic [SLOT_W-1:0]           launch_slot,
    input logic [SLOT_W-1:0]           req_slot,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [IDX_W-1:0]            bank_idx,
    input logic [ROW_W-1:0]            row,
    input logic [SLOTS-1:0][1:0]       pend_mode,
    input logic [SLOTS-1:0][CFG_W-1:0] pend_sel_a,
    input logic [SLOTS-1:0][1:0]       act_mode,
    input logic [SLOTS-1:0][CFG_W-1:0] act_sel_a,
    input logic [SLOTS-1:0][CFG_W-1:0] act_sel_b
);

    // R1 and R10: fold and reserved codes give the fold hash at the output.
    a_r1_fold_mapping: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode[req_slot] == 2'd1 || act_mode[req_slot] == 2'd3) |->
        bank_idx == (req_addr[IDX_W-1:0] ^ req_addr[2*IDX_W-1:IDX_W]));

    a_r2_basic_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode[req_slot] == 2'd0) |-> bank_idx == req_addr[IDX_W-1:0]);

    a_r6_row_upper: assert property (@(posedge clk) disable iff (!rst_n)
        row == req_addr[ADDR_W-1:IDX_W]);

    a_r7_write_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> pend_mode[$past(cfg_slot)] == $past(cfg_mode));

    a_r8_launch_copies: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |=> (act_mode[$past(launch_slot)] == $past(pend_mode[launch_slot]))
                      && (act_sel_a[$past(launch_slot)] == $past(pend_sel_a[launch_slot])));

    for (genvar s = 0; s < SLOTS; s++) begin : g_hold
        // R9 and R7: an active copy moves only on a launch of its own slot.
        a_r9_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(launch_valid && launch_slot == SLOT_W'(s)) |=>
            ($stable(act_mode[s]) && $stable(act_sel_a[s]) && $stable(act_sel_b[s])));
    end

endmodule

bind xbm_top xbm_checker #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode),
    .launch_valid(launch_valid), .launch_slot(launch_slot),
    .req_slot(req_slot), .req_addr(req_addr),
    .bank_idx(bank_idx), .row(row),
    .pend_mode(pend_mode), .pend_sel_a(pend_sel_a),
    .act_mode(act_mode), .act_sel_a(act_sel_a), .act_sel_b(act_sel_b)
);

// File: tb/tb_xbm_top.sv
module tb_xbm_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [1:0] cfg_slot;
    logic [1:0] cfg_mode;
    logic [19:0] cfg_sel_a;
    logic [19:0] cfg_sel_b;
    logic       launch_valid;
    logic [1:0] launch_slot;
    logic [1:0] req_slot;
    logic [9:0] req_addr;
    logic [4:0] bank_idx;
    logic [4:0] row;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    localparam logic [19:0] FOLD_A = {4'd4, 4'd3, 4'd2, 4'd1, 4'd0};
    localparam logic [19:0] FOLD_B = {4'd9, 4'd8, 4'd7, 4'd6, 4'd5};

    always #2 clk = ~clk;

    xbm_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_mode(cfg_mode), .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b),
        .launch_valid(launch_valid), .launch_slot(launch_slot),
        .req_slot(req_slot), .req_addr(req_addr),
        .bank_idx(bank_idx), .row(row)
    );

    function automatic logic pick(input logic [3:0] s, input logic [9:0] a);
        return (s < 4'd10) ? a[s] : 1'b0;
    endfunction

    // Reference mapping written from the requirements.
    function automatic logic [4:0] ref_bank(input int mode, input logic [19:0] sa,
                                            input logic [19:0] sb, input logic [9:0] a);
        logic [4:0] r;
        if (mode == 0) r = a[4:0];
        else if (mode == 2) begin
            for (int i = 0; i < 5; i++) begin
                if (sa[i*4 +: 4] == sb[i*4 +: 4]) r[i] = pick(sa[i*4 +: 4], a);
                else r[i] = pick(sa[i*4 +: 4], a) ^ pick(sb[i*4 +: 4], a);
            end
        end else r = a[4:0] ^ a[9:5];
        return r;
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present an access and compare bank and row after settling.
    task automatic probe(input int slot, input logic [9:0] a, input int mode,
                         input logic [19:0] sa, input logic [19:0] sb, input string tag);
        req_slot = 2'(slot);
        req_addr = a;
        #0.5;
        check(tag, bank_idx, ref_bank(mode, sa, sb, a));
        check("R6 row", row, a[9:5]);
    endtask

    task automatic write_cfg(input int slot, input int mode,
                             input logic [19:0] sa, input logic [19:0] sb);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 2'(slot); cfg_mode = 2'(mode);
        cfg_sel_a = sa; cfg_sel_b = sb;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic launch(input int slot);
        @(negedge clk);
        launch_valid = 1'b1; launch_slot = 2'(slot);
        @(negedge clk);
        launch_valid = 1'b0;
    endtask

    task automatic t_reset;
        for (int s = 0; s < 4; s++) begin
            probe(s, 10'h3A5, 1, FOLD_A, FOLD_B, "R1 reset fold");
            probe(s, 10'h0FF, 1, FOLD_A, FOLD_B, "R1 reset fold");
        end
    endtask

    task automatic t_basic;
        write_cfg(1, 0, FOLD_A, FOLD_B);
        probe(1, 10'h2B7, 1, FOLD_A, FOLD_B, "R7 write not yet applied");
        launch(1);
        probe(1, 10'h2B7, 0, FOLD_A, FOLD_B, "R2 basic");
        probe(1, 10'h1E3, 0, FOLD_A, FOLD_B, "R2 basic");
        probe(0, 10'h2B7, 1, FOLD_A, FOLD_B, "R9 other slot kept");
    endtask

    task automatic t_pair;
        logic [19:0] sa = {4'd8, 4'd6, 4'd4, 4'd2, 4'd0};
        logic [19:0] sb = {4'd1, 4'd3, 4'd5, 4'd7, 4'd9};
        write_cfg(2, 2, sa, sb);
        launch(2);
        probe(2, 10'h155, 2, sa, sb, "R3 pair");
        probe(2, 10'h2C9, 2, sa, sb, "R3 pair");
        probe(2, 10'h3FF, 2, sa, sb, "R3 pair");
        probe(1, 10'h2C9, 0, FOLD_A, FOLD_B, "R9 other slot kept");
    endtask

    task automatic t_equal_range;
        logic [19:0] sa = {4'd12, 4'd14, 4'd7, 4'd8, 4'd9};
        logic [19:0] sb = {4'd3,  4'd14, 4'd7, 4'd8, 4'd9};
        write_cfg(3, 2, sa, sb);
        launch(3);
        probe(3, 10'h30C, 2, sa, sb, "R4 R5 equal and out-of-range");
        probe(3, 10'h1FB, 2, sa, sb, "R4 R5 equal and out-of-range");
        req_addr = 10'h3FF; #0.5;
        check("R5 selector 14 reads zero", {4'b0, bank_idx[3]}, 5'd0);
        check("R4 equal selectors use one bit", {4'b0, bank_idx[0]}, 5'd1);
    endtask

    task automatic t_latency;
        write_cfg(0, 0, FOLD_A, FOLD_B);
        @(negedge clk);
        launch_valid = 1'b1; launch_slot = 2'd0;
        probe(0, 10'h3A5, 1, FOLD_A, FOLD_B, "R8 before launch edge");
        @(posedge clk);
        #1;
        probe(0, 10'h3A5, 0, FOLD_A, FOLD_B, "R8 after launch edge");
        @(negedge clk);
        launch_valid = 1'b0;
    endtask

    task automatic t_same_cycle;
        logic [19:0] sa = {4'd0, 4'd1, 4'd2, 4'd3, 4'd4};
        logic [19:0] sb = {4'd5, 4'd5, 4'd5, 4'd5, 4'd5};
        write_cfg(0, 1, FOLD_A, FOLD_B);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 2'd0; cfg_mode = 2'd2; cfg_sel_a = sa; cfg_sel_b = sb;
        launch_valid = 1'b1; launch_slot = 2'd0;
        @(negedge clk);
        cfg_we = 1'b0; launch_valid = 1'b0;
        probe(0, 10'h2D6, 1, FOLD_A, FOLD_B, "R8 same-cycle write stays pending");
        launch(0);
        probe(0, 10'h2D6, 2, sa, sb, "R8 pending applied on next launch");
    endtask

    task automatic t_reserved;
        write_cfg(1, 3, 20'h0, 20'h0);
        launch(1);
        probe(1, 10'h3A5, 1, FOLD_A, FOLD_B, "R10 reserved code folds");
        probe(1, 10'h16B, 1, FOLD_A, FOLD_B, "R10 reserved code folds");
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_slot = '0; cfg_mode = '0;
        cfg_sel_a = '0; cfg_sel_b = '0; launch_valid = 1'b0; launch_slot = '0;
        req_slot = '0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_pair();
        t_equal_range();
        t_latency();
        t_same_cycle();
        t_reserved();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule